// File: doc/BRIEF.md
# Pending Memory Request Line Matcher

This block keeps a bank of pending memory-request cells and answers, in one pass, which of them fall inside a given cache line. Every cell holds the 8-byte-word address of one request, a byte mask naming the bytes it touches inside that word, and whether the request is a load or a store. A request that straddles a word boundary is handed in as two cells, one for the low part and one for the high part. Each cell applies only to its own word.

One or more probe lanes each broadcast a line address to all cells at the same time. Each lane has its own compare network. It returns a vector of the cells that hit, the OR of their byte masks placed at their word positions within the line, and a flag raised when that merged mask covers every byte of the line. A separate pairwise network keeps watching the stored cells. It marks any cell whose bytes collide with another cell's bytes in the same word when at least one of the two is a store, so a scheduler can keep those accesses apart.

Cells are filled through a valid/ready write port that names the target cell. The port applies back-pressure: `wr_ready` is low while the named cell is still occupied or the index is out of range, and a write is taken only on a cycle where `wr_valid` and `wr_ready` are both high. Cells are emptied through a per-cell release strobe. Probe results have no back-pressure. They are registered and presented for one cycle.

Top module: `mreq_match_bank`

## Requirements
- R1: After reset, all cells are empty, `hit_valid` is 0 on every lane, `conflict` is all zero, and `wr_ready` is high for any in-range index.
- R2: `wr_ready` is low when `wr_idx` is NCELL or above, or when the named cell is occupied. A write offered to an occupied cell leaves that cell's contents unchanged.
- R3: Setting `rel[i]` empties cell i at the next clock edge. After that edge the cell no longer hits, no longer takes part in conflicts, and accepts a new write.
- R4: On a probe lane, `hit_vec[l][i]` is 1 one cycle after `bc_valid[l]` when cell i is occupied and its address matches the broadcast address in bits AW-1 down to 3+log2(LINE_WORDS). Address bits 2:0 of both the cell and the broadcast never affect the result.
- R5: `line_be[l]` is the OR of the masks of the hitting cells. Mask bit b of a cell whose word index within the line is w (address bits 3+log2(LINE_WORDS)-1 down to 3) sets `line_be` bit 8*w+b.
- R6: `line_full[l]` is 1 exactly when `hit_valid[l]` is 1 and every bit of `line_be[l]` is set.
- R7: Each probe lane is evaluated on its own. Different lines probed in the same cycle give independent results.
- R8: `hit_valid[l]` follows `bc_valid[l]` with one cycle of delay. When `hit_valid[l]` is 0, `hit_vec[l]`, `line_be[l]` and `line_full[l]` are 0.
- R9: `conflict[i]` is 1 one cycle after the stored state shows that cell i and another occupied cell have equal word addresses (bits AW-1:3), share at least one mask bit, and at least one of the two is a store (`wr_store`=1). The two cells may have different byte offsets.
- R10: Two loads (`wr_store`=0) that touch the same bytes never raise `conflict`.
- R11: Cells in the same word whose masks share no bit never raise `conflict`, even when one of them is a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request for a cell |
| wr_ready | output | 1 | Target cell is free and the index is in range |
| wr_idx | input | IW (4) | Index of the target cell |
| wr_addr | input | AW (48) | Byte address of the request |
| wr_mask | input | 8 | Bytes touched inside the 8-byte word |
| wr_store | input | 1 | 1 for a store, 0 for a load |
| rel | input | NCELL (12) | Per-cell release strobe |
| bc_valid | input | NLANE (2) | Probe request for each lane |
| bc_addr | input | NLANE x AW | Line address broadcast on each lane |
| hit_valid | output | NLANE | Probe result valid for each lane |
| hit_vec | output | NLANE x NCELL | Cells that hit on each lane |
| line_be | output | NLANE x 8*LINE_WORDS | Merged byte enables for each lane |
| line_full | output | NLANE | Merged mask covers the whole line |
| conflict | output | NCELL | Cell collides with another cell |

## Verification
The bench builds the block with its defaults: twelve cells, two probe lanes and a four-word (32-byte) line. Twelve cells are enough to cover a full line with four cells and still leave room for a misaligned pair and for cells that overlap or just miss each other. Two lanes allow the same-cycle independence of R7 to be probed with one line full and the other partial. The four-word line puts each word at a distinct offset in `line_be`, so the check of R5 sees a wrong word placement.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  localparam int MREQ_CELLS      = 12;
  localparam int MREQ_ADDR_W     = 48;
  localparam int MREQ_LANES      = 2;
  localparam int MREQ_LINE_WORDS = 4;
  localparam int MREQ_WORD_BYTES = 8;
  localparam int MREQ_WOFF       = 3;

  typedef enum logic {
    REQ_LOAD  = 1'b0,
    REQ_STORE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/mreq_cell_store.sv
module mreq_cell_store #(
  parameter int NCELL = mreq_pkg::MREQ_CELLS,
  parameter int AW    = mreq_pkg::MREQ_ADDR_W,
  parameter int MB    = mreq_pkg::MREQ_WORD_BYTES,
  parameter int IW    = $clog2(NCELL + 1),
  localparam int WA   = AW - mreq_pkg::MREQ_WOFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [IW-1:0]              wr_idx,
  input  logic [AW-1:0]              wr_addr,
  input  logic [MB-1:0]              wr_mask,
  input  logic                       wr_store,
  input  logic [NCELL-1:0]           rel,
  output logic [NCELL-1:0]           cell_vld,
  output logic [NCELL-1:0][WA-1:0]   cell_word,
  output logic [NCELL-1:0][MB-1:0]   cell_mask,
  output logic [NCELL-1:0]           cell_st
);
  logic idx_ok;
  logic sel_busy;

  always_comb begin
    idx_ok   = (wr_idx < IW'(NCELL));
    sel_busy = 1'b1;
    for (int c = 0; c < NCELL; c++) begin
      if (wr_idx == IW'(c)) sel_busy = cell_vld[c];
    end
  end

  assign wr_ready = idx_ok && !sel_busy;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic take;
    assign take = wr_valid && wr_ready && (wr_idx == IW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cell_vld[c]  <= 1'b0;
        cell_word[c] <= '0;
        cell_mask[c] <= '0;
        cell_st[c]   <= mreq_pkg::REQ_LOAD;
      end else if (take) begin
        cell_vld[c]  <= 1'b1;
        cell_word[c] <= wr_addr[AW-1:mreq_pkg::MREQ_WOFF];
        cell_mask[c] <= wr_mask;
        cell_st[c]   <= wr_store;
      end else if (rel[c]) begin
        cell_vld[c]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mreq_line_probe.sv
module mreq_line_probe #(
  parameter int NCELL = mreq_pkg::MREQ_CELLS,
  parameter int WA    = mreq_pkg::MREQ_ADDR_W - mreq_pkg::MREQ_WOFF,
  parameter int MB    = mreq_pkg::MREQ_WORD_BYTES,
  parameter int LW    = mreq_pkg::MREQ_LINE_WORDS,
  localparam int LWB  = $clog2(LW),
  localparam int LB   = LW * MB
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bc_valid,
  input  logic [WA-1:0]              bc_word,
  input  logic [NCELL-1:0]           cell_vld,
  input  logic [NCELL-1:0][WA-1:0]   cell_word,
  input  logic [NCELL-1:0][MB-1:0]   cell_mask,
  output logic                       hit_valid,
  output logic [NCELL-1:0]           hit_vec,
  output logic [LB-1:0]              line_be,
  output logic                       line_full
);
  logic [NCELL-1:0] hit_n;
  logic [LB-1:0]    be_n;
  logic             full_n;

  for (genvar c = 0; c < NCELL; c++) begin : g_cmp
    assign hit_n[c] = cell_vld[c] && (cell_word[c][WA-1:LWB] == bc_word[WA-1:LWB]);
  end

  always_comb begin
    be_n = '0;
    for (int c = 0; c < NCELL; c++) begin
      for (int w = 0; w < LW; w++) begin
        if (hit_n[c] && (cell_word[c][LWB-1:0] == LWB'(w)))
          be_n[w*MB +: MB] = be_n[w*MB +: MB] | cell_mask[c];
      end
    end
    full_n = &be_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bc_valid) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
      line_be   <= '0;
      line_full <= 1'b0;
    end else begin
      hit_valid <= 1'b1;
      hit_vec   <= hit_n;
      line_be   <= be_n;
      line_full <= full_n;
    end
  end
endmodule

// File: rtl/mreq_overlap_net.sv
module mreq_overlap_net #(
  parameter int NCELL = mreq_pkg::MREQ_CELLS,
  parameter int WA    = mreq_pkg::MREQ_ADDR_W - mreq_pkg::MREQ_WOFF,
  parameter int MB    = mreq_pkg::MREQ_WORD_BYTES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCELL-1:0]           cell_vld,
  input  logic [NCELL-1:0][WA-1:0]   cell_word,
  input  logic [NCELL-1:0][MB-1:0]   cell_mask,
  input  logic [NCELL-1:0]           cell_st,
  output logic [NCELL-1:0]           conflict
);
  logic [NCELL-1:0] clash_n;

  always_comb begin
    clash_n = '0;
    for (int i = 0; i < NCELL; i++) begin
      for (int j = 0; j < NCELL; j++) begin
        if (i != j && cell_vld[i] && cell_vld[j] &&
            (cell_word[i] == cell_word[j]) &&
            (|(cell_mask[i] & cell_mask[j])) &&
            (cell_st[i] || cell_st[j]))
          clash_n[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) conflict <= '0;
    else        conflict <= clash_n;
  end
endmodule

// File: rtl/mreq_match_bank.sv
module mreq_match_bank #(
  parameter int NCELL      = mreq_pkg::MREQ_CELLS,
  parameter int AW         = mreq_pkg::MREQ_ADDR_W,
  parameter int NLANE      = mreq_pkg::MREQ_LANES,
  parameter int LINE_WORDS = mreq_pkg::MREQ_LINE_WORDS,
  localparam int MB        = mreq_pkg::MREQ_WORD_BYTES,
  localparam int WA        = AW - mreq_pkg::MREQ_WOFF,
  localparam int LB        = LINE_WORDS * MB,
  localparam int IW        = $clog2(NCELL + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [IW-1:0]                wr_idx,
  input  logic [AW-1:0]                wr_addr,
  input  logic [MB-1:0]                wr_mask,
  input  logic                         wr_store,
  input  logic [NCELL-1:0]             rel,
  input  logic [NLANE-1:0]             bc_valid,
  input  logic [NLANE-1:0][AW-1:0]     bc_addr,
  output logic [NLANE-1:0]             hit_valid,
  output logic [NLANE-1:0][NCELL-1:0]  hit_vec,
  output logic [NLANE-1:0][LB-1:0]     line_be,
  output logic [NLANE-1:0]             line_full,
  output logic [NCELL-1:0]             conflict
);
  logic [NCELL-1:0]         cell_vld;
  logic [NCELL-1:0][WA-1:0] cell_word;
  logic [NCELL-1:0][MB-1:0] cell_mask;
  logic [NCELL-1:0]         cell_st;

  mreq_cell_store #(.NCELL(NCELL), .AW(AW), .MB(MB), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_store(wr_store),
    .rel(rel),
    .cell_vld(cell_vld), .cell_word(cell_word),
    .cell_mask(cell_mask), .cell_st(cell_st)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    mreq_line_probe #(.NCELL(NCELL), .WA(WA), .MB(MB), .LW(LINE_WORDS)) u_probe (
      .clk(clk), .rst_n(rst_n),
      .bc_valid(bc_valid[l]),
      .bc_word(bc_addr[l][AW-1:mreq_pkg::MREQ_WOFF]),
      .cell_vld(cell_vld), .cell_word(cell_word), .cell_mask(cell_mask),
      .hit_valid(hit_valid[l]), .hit_vec(hit_vec[l]),
      .line_be(line_be[l]), .line_full(line_full[l])
    );
  end

  mreq_overlap_net #(.NCELL(NCELL), .WA(WA), .MB(MB)) u_overlap (
    .clk(clk), .rst_n(rst_n),
    .cell_vld(cell_vld), .cell_word(cell_word),
    .cell_mask(cell_mask), .cell_st(cell_st),
    .conflict(conflict)
  );
endmodule

// File: rtl/mreq_match_bank_chk.sv
module mreq_match_bank_chk #(
  parameter int NCELL = 12,
  parameter int NLANE = 2,
  parameter int LB    = 32,
  parameter int IW    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_ready,
  input logic [IW-1:0]               wr_idx,
  input logic [NLANE-1:0]            bc_valid,
  input logic [NLANE-1:0]            hit_valid,
  input logic [NLANE-1:0][NCELL-1:0] hit_vec,
  input logic [NLANE-1:0][LB-1:0]    line_be,
  input logic [NLANE-1:0]            line_full,
  input logic [NCELL-1:0]            conflict
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hit_valid == '0 && conflict == '0));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx >= IW'(NCELL)) |-> !wr_ready);

  // R9
  pair_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(conflict) != 1);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane_chk
    // R8
    lane_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid[l] |=> hit_valid[l]);

    // R8
    lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bc_valid[l] |=> (!hit_valid[l] && hit_vec[l] == '0 &&
                        line_be[l] == '0 && !line_full[l]));

    // R5
    be_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|line_be[l]) |-> (|hit_vec[l]));

    // R6
    full_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_full[l] |-> (hit_valid[l] && (&line_be[l])));
  end
endmodule

bind mreq_match_bank mreq_match_bank_chk #(
  .NCELL(NCELL), .NLANE(NLANE), .LB(LB), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .wr_idx(wr_idx),
  .bc_valid(bc_valid), .hit_valid(hit_valid), .hit_vec(hit_vec),
  .line_be(line_be), .line_full(line_full), .conflict(conflict)
);

// File: tb/mreq_match_bank_test.sv
module mreq_match_bank_test;
  localparam int NCELL = 12;
  localparam int AW    = 48;
  localparam int NLANE = 2;
  localparam int LW    = 4;
  localparam int LB    = LW * 8;
  localparam int IW    = 4;
  localparam logic [AW-1:0] LINE_A = 48'h0000_1234_5600;
  localparam logic [AW-1:0] LINE_B = 48'h0000_0ABC_DE20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_mask = '0;
  logic wr_store = 1'b0;
  logic [NCELL-1:0] rel = '0;
  logic [NLANE-1:0] bc_valid = '0;
  logic [NLANE-1:0][AW-1:0] bc_addr = '0;
  logic [NLANE-1:0] hit_valid;
  logic [NLANE-1:0][NCELL-1:0] hit_vec;
  logic [NLANE-1:0][LB-1:0] line_be;
  logic [NLANE-1:0] line_full;
  logic [NCELL-1:0] conflict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mreq_match_bank uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_store(wr_store),
    .rel(rel), .bc_valid(bc_valid), .bc_addr(bc_addr),
    .hit_valid(hit_valid), .hit_vec(hit_vec), .line_be(line_be),
    .line_full(line_full), .conflict(conflict)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [AW-1:0] a, input logic [7:0] m,
                     input logic st, input logic exp_rdy, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = IW'(idx); wr_addr = a; wr_mask = m; wr_store = st;
    #1;
    chk(req, {63'b0, wr_ready}, {63'b0, exp_rdy});
    @(negedge clk);
    wr_valid = 1'b0; wr_idx = '0;
  endtask

  task automatic probe(input logic v0, input logic [AW-1:0] a0,
                       input logic v1, input logic [AW-1:0] a1);
    @(negedge clk);
    bc_valid = {v1, v0}; bc_addr[0] = a0; bc_addr[1] = a1;
    @(negedge clk);
    bc_valid = '0;
  endtask

  task automatic lane_chk(input int l, input string req, input logic [NCELL-1:0] ev,
                          input logic [LB-1:0] ebe, input logic ef);
    chk({req, " hit_valid"}, {63'b0, hit_valid[l]}, 64'd1);
    chk({req, " hit_vec"}, {52'b0, hit_vec[l]}, {52'b0, ev});
    chk({req, " line_be"}, {32'b0, line_be[l]}, {32'b0, ebe});
    chk({req, " line_full"}, {63'b0, line_full[l]}, {63'b0, ef});
  endtask

  task automatic conf_chk(input string req, input logic [NCELL-1:0] exp);
    @(negedge clk);
    chk(req, {52'b0, conflict}, {52'b0, exp});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hit_valid", {62'b0, hit_valid}, 64'd0);
    chk("R1 conflict", {52'b0, conflict}, 64'd0);
    wr_idx = 4'd5; #1;
    chk("R1 wr_ready", {63'b0, wr_ready}, 64'd1);
    wr_idx = '0;
  endtask

  task automatic t_full_line();
    for (int w = 0; w < 4; w++) put(w, LINE_A + AW'(8*w), 8'hFF, 1'b0, 1'b1, "R2 free");
    probe(1'b1, LINE_A | 48'h7, 1'b1, LINE_B);
    lane_chk(0, "R4 R6 full", 12'h00F, 32'hFFFF_FFFF, 1'b1);
    lane_chk(1, "R7 miss lane", 12'h000, 32'h0, 1'b0);
  endtask

  task automatic t_split();
    put(4, LINE_B + 48'd8 + 48'd4, 8'hF0, 1'b1, 1'b1, "R2 free");
    put(5, LINE_B + 48'd16, 8'h0F, 1'b0, 1'b1, "R2 free");
    probe(1'b1, LINE_A, 1'b1, LINE_B + 48'd3);
    lane_chk(0, "R7 lane0", 12'h00F, 32'hFFFF_FFFF, 1'b1);
    lane_chk(1, "R5 split", 12'h030, 32'h000F_F000, 1'b0);
    conf_chk("R11 no clash", 12'h000);
  endtask

  task automatic t_backpressure();
    put(0, LINE_B, 8'hFF, 1'b1, 1'b0, "R2 busy");
    put(12, LINE_B, 8'hFF, 1'b1, 1'b0, "R2 range12");
    put(15, LINE_B, 8'hFF, 1'b1, 1'b0, "R2 range15");
    probe(1'b1, LINE_A, 1'b1, LINE_B);
    lane_chk(0, "R2 kept", 12'h00F, 32'hFFFF_FFFF, 1'b1);
    lane_chk(1, "R2 not taken", 12'h030, 32'h000F_F000, 1'b0);
  endtask

  task automatic t_overlap();
    put(6, LINE_A, 8'h01, 1'b0, 1'b1, "R2 free");
    conf_chk("R10 loads", 12'h000);
    put(7, LINE_A + 48'd3, 8'h08, 1'b1, 1'b1, "R2 free");
    conf_chk("R9 store clash", 12'h081);
    put(8, LINE_B + 48'd8, 8'h0F, 1'b1, 1'b1, "R2 free");
    conf_chk("R11 disjoint", 12'h081);
  endtask

  task automatic t_release();
    @(negedge clk); rel = 12'h080;
    @(negedge clk); rel = '0;
    conf_chk("R3 clash gone", 12'h000);
    @(negedge clk); rel = 12'h00F;
    @(negedge clk); rel = '0;
    probe(1'b0, LINE_A, 1'b1, LINE_A);
    lane_chk(1, "R3 released", 12'h040, 32'h0000_0001, 1'b0);
    chk("R8 idle lane", {63'b0, hit_valid[0]}, 64'd0);
    put(0, LINE_A + 48'd24, 8'hFF, 1'b0, 1'b1, "R3 reuse");
    probe(1'b1, LINE_A, 1'b0, LINE_B);
    lane_chk(0, "R3 R5 refill", 12'h041, 32'hFF00_0001, 1'b0);
    @(negedge clk);
    chk("R8 drop valid", {62'b0, hit_valid}, 64'd0);
    chk("R8 zero vec", {40'b0, hit_vec}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_full_line();
    t_split();
    t_backpressure();
    t_overlap();
    t_release();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule